// File: doc/BRIEF.md
# Dual-Window Security Configuration Register File

This block is a 32-bit register file reached through two independent request ports, each addressing its own 4 KB window. The secure window holds the bus-error response select, the callable-region configuration, the protection-controller interrupt enable and clear registers, the bridge interrupt enable, and the non-secure and secure-privileged access masks of every protection-controller slice. The non-secure window holds only the non-secure-privileged masks of the same slices, plus a block of identification bytes.

Each write to a mask register lands in one slice of an array of protection-controller slices. The slices are split into an internal group, an expansion APB group and an expansion AHB group. Every slice's three masks leave the block on flat buses for the slice datapaths to consume. Interrupt status is held outside the block. Its current value comes in on plain input buses, and a clear write leaves as a one-cycle pulse.

Reads return zero-extended bytes or halfwords taken from the addressed lane. Writes narrower than a word are dropped without a trace. A full-word write to a read-only or undecoded offset is dropped and raises a one-cycle error pulse on the port that issued it.

Top module: `sec_cfg_banks`

## Requirements
- R1: After reset, the response select, the callable configuration, the interrupt enable, the bridge enable, every slice mask, both read data buses, both error flags and the clear pulse bus are all zero.
- R2: A full-word write at secure offset 0x10 keeps only bit 0, which drives `resp_cfg_o`. A full-word write at 0x14 keeps bits [1:0], which drive `call_cfg_o`. Both outputs change on the write's clock edge and can be read back, and each holds its value while no write reaches it.
- R3: In the secure window, offsets 0x60/0x70/0x80 (0xA0/0xB0/0xC0 for the secure-privileged masks) start the expansion-AHB, internal and expansion-APB non-secure mask groups. Address bits [3:2] pick the slice within a group. Slices are numbered internal first (0..1), then expansion APB (2..5), then expansion AHB (6..9). Only the low PORTS bits (16) are stored and driven on the slice buses.
- R4: The non-secure window decodes only 0xA0 (expansion AHB), 0xB0 (internal) and 0xC0 (expansion APB) as non-secure-privileged masks. These are separate from the secure masks at the same offsets in the other window.
- R5: A write whose size code is not 2'b10 (codes: 2'b00 byte, 2'b01 halfword, 2'b10 word) changes no state and raises no error.
- R6: A byte or halfword read returns the word shifted right by 8 × addr[1:0], masked to 8 or 16 bits, and zero-extended.
- R7: Reads of the write-only clear offsets 0x24 and 0x44, and of undecoded offsets, return zero.
- R8: The interrupt enable at 0x28 keeps the bits in 0x00F000F3 and drives `ppc_irq_en_o`. The bridge enable at 0x48 keeps bits [31:16]. The bridge status at 0x40 always reads zero.
- R9: Secure 0x50 and 0x90, and non-secure 0x90, read as zero and ignore writes.
- R10: Offsets 0xFD0..0xFFC in both windows read one identification byte each: 04,00,00,00, part-low, B8, 0B, 00, 0D, F0, 05, B1. The part-low byte is 0x52 in the secure window and 0x53 in the non-secure window.
- R11: A full-word write to a read-only or undecoded offset changes no state, and that port's error flag is high for exactly the one cycle after the write's edge.
- R12: Secure 0x1C and 0x20 read the `mpc_stat_i` and `ppc_stat_i` inputs. A full-word write to 0x24 drives `ppc_irq_clr_o` to the write data ANDed with 0x00F000F3 for exactly one cycle.
- R13: Read data is registered. It is valid in the cycle after the read request and holds until the next read on that port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_req | input | 1 | Secure window access strobe |
| sec_wr | input | 1 | Secure access is a write |
| sec_addr | input | 12 | Secure window byte offset |
| sec_size | input | 2 | Secure access size code |
| sec_wdata | input | 32 | Secure write data |
| sec_rdata | output | 32 | Secure read data |
| sec_err | output | 1 | Secure bad-write pulse |
| nsw_req | input | 1 | Non-secure window access strobe |
| nsw_wr | input | 1 | Non-secure access is a write |
| nsw_addr | input | 12 | Non-secure window byte offset |
| nsw_size | input | 2 | Non-secure access size code |
| nsw_wdata | input | 32 | Non-secure write data |
| nsw_rdata | output | 32 | Non-secure read data |
| nsw_err | output | 1 | Non-secure bad-write pulse |
| mpc_stat_i | input | 32 | Memory-protection interrupt status |
| ppc_stat_i | input | 32 | Peripheral-protection interrupt status |
| resp_cfg_o | output | 1 | Bus-error response select |
| call_cfg_o | output | 2 | Callable-region configuration |
| ppc_irq_en_o | output | 32 | Protection interrupt enables |
| ppc_irq_clr_o | output | 32 | One-cycle protection interrupt clear |
| slice_ns_o | output | NSLICE*PORTS | Non-secure masks, slice 0 in the low bits |
| slice_sp_o | output | NSLICE*PORTS | Secure-privileged masks |
| slice_nsp_o | output | NSLICE*PORTS | Non-secure-privileged masks |

## Verification
Configuration outputs, slice buses and stored enables change on the clock edge that samples a full-word write, so they are due one edge after the request. Read data, the error flags and the clear pulse come from registers loaded on that same edge. The bench raises each request at a falling edge, waits through one rising edge, and samples everything at the next falling edge, where all of these results are due. The single-cycle error and clear pulses are sampled once more one cycle later, where they must already be zero.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;

   typedef enum logic [3:0] {
      F_NONE, F_RESP, F_CALL, F_MPCST, F_PPCST, F_PPCCLR, F_PPCEN,
      F_BRGST, F_BRGCLR, F_BRGEN, F_RAZ, F_NSM, F_SPM, F_NSPM, F_ID
   } field_e;

   typedef struct packed {
      field_e     kind;
      logic [3:0] idx;
   } dec_t;

   localparam logic [1:0]  SZ_BYTE     = 2'b00;
   localparam logic [1:0]  SZ_HALF     = 2'b01;
   localparam logic [1:0]  SZ_WORD     = 2'b10;
   localparam logic [31:0] PPC_EN_MASK = 32'h00F0_00F3;
   localparam logic [31:0] BRG_EN_MASK = 32'hFFFF_0000;
   localparam int          ID_COUNT    = 12;
   localparam int          MAX_SLICE   = 16;

   function automatic logic writable(input field_e k);
      case (k)
         F_RESP, F_CALL, F_PPCCLR, F_PPCEN, F_BRGCLR, F_BRGEN,
         F_NSM, F_SPM, F_NSPM: writable = 1'b1;
         default:              writable = 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] id_byte(input logic [3:0] idx,
                                          input logic       secure,
                                          input logic [7:0] rev);
      case (idx)
         4'd0:    id_byte = 8'h04;
         4'd4:    id_byte = secure ? 8'h52 : 8'h53;
         4'd5:    id_byte = 8'hB8;
         4'd6:    id_byte = rev;
         4'd8:    id_byte = 8'h0D;
         4'd9:    id_byte = 8'hF0;
         4'd10:   id_byte = 8'h05;
         4'd11:   id_byte = 8'hB1;
         default: id_byte = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/sec_cfg_decode.sv
module sec_cfg_decode
   import sec_cfg_pkg::*;
#(
   parameter bit SECURE = 1'b1,
   parameter int N_INT  = 2,
   parameter int N_EXP  = 4
) (
   input  logic [11:0] addr,
   output dec_t        dec
);
   localparam int BASE_INT  = 0;
   localparam int BASE_APBX = N_INT;
   localparam int BASE_AHBX = N_INT + N_EXP;

   logic [7:0] grp;
   logic [1:0] sub;
   dec_t       win;

   assign grp = addr[11:4];
   assign sub = addr[3:2];

   function automatic dec_t pick(input field_e k, input logic [1:0] s,
                                 input int base, input int cnt);
      dec_t d;
      d.kind = F_NONE;
      d.idx  = 4'd0;
      if (int'(s) < cnt) begin
         d.kind = k;
         d.idx  = 4'(base + int'(s));
      end
      return d;
   endfunction

   generate
      if (SECURE) begin : g_sec
         always_comb begin
            win = '{kind: F_NONE, idx: 4'd0};
            case (grp)
               8'h01: begin
                  case (sub)
                     2'd0:    win.kind = F_RESP;
                     2'd1:    win.kind = F_CALL;
                     2'd3:    win.kind = F_MPCST;
                     default: win.kind = F_NONE;
                  endcase
               end
               8'h02: begin
                  case (sub)
                     2'd0:    win.kind = F_PPCST;
                     2'd1:    win.kind = F_PPCCLR;
                     2'd2:    win.kind = F_PPCEN;
                     default: win.kind = F_NONE;
                  endcase
               end
               8'h04: begin
                  case (sub)
                     2'd0:    win.kind = F_BRGST;
                     2'd1:    win.kind = F_BRGCLR;
                     2'd2:    win.kind = F_BRGEN;
                     default: win.kind = F_NONE;
                  endcase
               end
               8'h05, 8'h09: if (sub == 2'd0) win.kind = F_RAZ;
               8'h06: win = pick(F_NSM, sub, BASE_AHBX, N_EXP);
               8'h07: win = pick(F_NSM, sub, BASE_INT,  N_INT);
               8'h08: win = pick(F_NSM, sub, BASE_APBX, N_EXP);
               8'h0A: win = pick(F_SPM, sub, BASE_AHBX, N_EXP);
               8'h0B: win = pick(F_SPM, sub, BASE_INT,  N_INT);
               8'h0C: win = pick(F_SPM, sub, BASE_APBX, N_EXP);
               default: win = '{kind: F_NONE, idx: 4'd0};
            endcase
         end
      end else begin : g_nsw
         always_comb begin
            win = '{kind: F_NONE, idx: 4'd0};
            case (grp)
               8'h09: if (sub == 2'd0) win.kind = F_RAZ;
               8'h0A: win = pick(F_NSPM, sub, BASE_AHBX, N_EXP);
               8'h0B: win = pick(F_NSPM, sub, BASE_INT,  N_INT);
               8'h0C: win = pick(F_NSPM, sub, BASE_APBX, N_EXP);
               default: win = '{kind: F_NONE, idx: 4'd0};
            endcase
         end
      end
   endgenerate

   always_comb begin
      dec = win;
      if (grp >= 8'hFD) begin
         dec.kind = F_ID;
         dec.idx  = {grp[1:0] - 2'd1, sub};
      end
   end

endmodule

// File: rtl/sec_cfg_mask_bank.sv
module sec_cfg_mask_bank
   import sec_cfg_pkg::*;
#(
   parameter int NSLICE = 10,
   parameter int PORTS  = 16,
   localparam int BUSW  = NSLICE * PORTS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_we,
   input  field_e           s_kind,
   input  logic [3:0]       s_idx,
   input  logic [PORTS-1:0] s_wdata,
   input  logic             n_we,
   input  logic [3:0]       n_idx,
   input  logic [PORTS-1:0] n_wdata,
   output logic [BUSW-1:0]  ns_o,
   output logic [BUSW-1:0]  sp_o,
   output logic [BUSW-1:0]  nsp_o
);

   for (genvar g = 0; g < NSLICE; g++) begin : g_slice
      logic [PORTS-1:0] ns_q, sp_q, nsp_q;
      logic             ns_we, sp_we, nsp_we;

      assign ns_we  = s_we && (s_kind == F_NSM) && (s_idx == 4'(g));
      assign sp_we  = s_we && (s_kind == F_SPM) && (s_idx == 4'(g));
      assign nsp_we = n_we && (n_idx == 4'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ns_q  <= '0;
            sp_q  <= '0;
            nsp_q <= '0;
         end else begin
            if (ns_we)  ns_q  <= s_wdata;
            if (sp_we)  sp_q  <= s_wdata;
            if (nsp_we) nsp_q <= n_wdata;
         end
      end

      assign ns_o [g*PORTS +: PORTS] = ns_q;
      assign sp_o [g*PORTS +: PORTS] = sp_q;
      assign nsp_o[g*PORTS +: PORTS] = nsp_q;

      AST_NS_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !(s_we && s_kind == F_NSM) |=> $stable(ns_o[g*PORTS +: PORTS])); // R3
      AST_NSP_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !n_we |=> $stable(nsp_o[g*PORTS +: PORTS])); // R4
   end

endmodule

// File: rtl/sec_cfg_lane.sv
module sec_cfg_lane
   import sec_cfg_pkg::*;
(
   input  logic [31:0] word,
   input  logic [1:0]  lo,
   input  logic [1:0]  size,
   output logic [31:0] lane
);
   logic [31:0] shifted;

   assign shifted = word >> {lo, 3'b000};

   always_comb begin
      case (size)
         SZ_BYTE: lane = {24'h0, shifted[7:0]};
         SZ_HALF: lane = {16'h0, shifted[15:0]};
         default: lane = word;
      endcase
   end

endmodule

// File: rtl/sec_cfg_banks.sv
module sec_cfg_banks
   import sec_cfg_pkg::*;
#(
   parameter int         PORTS  = 16,
   parameter int         N_INT  = 2,
   parameter int         N_EXP  = 4,
   parameter logic [7:0] ID_REV = 8'h0B,
   localparam int NSLICE = N_INT + 2 * N_EXP,
   localparam int BUSW   = NSLICE * PORTS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sec_req,
   input  logic            sec_wr,
   input  logic [11:0]     sec_addr,
   input  logic [1:0]      sec_size,
   input  logic [31:0]     sec_wdata,
   output logic [31:0]     sec_rdata,
   output logic            sec_err,
   input  logic            nsw_req,
   input  logic            nsw_wr,
   input  logic [11:0]     nsw_addr,
   input  logic [1:0]      nsw_size,
   input  logic [31:0]     nsw_wdata,
   output logic [31:0]     nsw_rdata,
   output logic            nsw_err,
   input  logic [31:0]     mpc_stat_i,
   input  logic [31:0]     ppc_stat_i,
   output logic            resp_cfg_o,
   output logic [1:0]      call_cfg_o,
   output logic [31:0]     ppc_irq_en_o,
   output logic [31:0]     ppc_irq_clr_o,
   output logic [BUSW-1:0] slice_ns_o,
   output logic [BUSW-1:0] slice_sp_o,
   output logic [BUSW-1:0] slice_nsp_o
);

   generate
      if (N_INT < 1 || N_INT > 4) begin : g_bad_int
         $error("N_INT must be 1..4");
      end
      if (N_EXP < 1 || N_EXP > 4) begin : g_bad_exp
         $error("N_EXP must be 1..4");
      end
      if (PORTS < 1 || PORTS > 32) begin : g_bad_ports
         $error("PORTS must be 1..32");
      end
      if (NSLICE > MAX_SLICE) begin : g_bad_slices
         $error("too many slices");
      end
      if (PORTS < 32) begin : g_sink
         logic unused_hi;
         assign unused_hi = ^nsw_wdata[31:PORTS];
      end
   endgenerate

   dec_t sdec, ndec;

   sec_cfg_decode #(.SECURE(1'b1), .N_INT(N_INT), .N_EXP(N_EXP)) u_sdec (
      .addr(sec_addr), .dec(sdec));
   sec_cfg_decode #(.SECURE(1'b0), .N_INT(N_INT), .N_EXP(N_EXP)) u_ndec (
      .addr(nsw_addr), .dec(ndec));

   logic s_wacc, s_wok, s_wbad, n_wacc, n_wok, n_wbad;
   assign s_wacc = sec_req && sec_wr && (sec_size == SZ_WORD);
   assign s_wok  = s_wacc &&  writable(sdec.kind);
   assign s_wbad = s_wacc && !writable(sdec.kind);
   assign n_wacc = nsw_req && nsw_wr && (nsw_size == SZ_WORD);
   assign n_wok  = n_wacc &&  writable(ndec.kind);
   assign n_wbad = n_wacc && !writable(ndec.kind);

   sec_cfg_mask_bank #(.NSLICE(NSLICE), .PORTS(PORTS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_we    (s_wok && (sdec.kind == F_NSM || sdec.kind == F_SPM)),
      .s_kind  (sdec.kind),
      .s_idx   (sdec.idx),
      .s_wdata (sec_wdata[PORTS-1:0]),
      .n_we    (n_wok && ndec.kind == F_NSPM),
      .n_idx   (ndec.idx),
      .n_wdata (nsw_wdata[PORTS-1:0]),
      .ns_o    (slice_ns_o),
      .sp_o    (slice_sp_o),
      .nsp_o   (slice_nsp_o)
   );

   logic        resp_q;
   logic [1:0]  call_q;
   logic [31:0] ppc_en_q, brg_en_q, clr_q;
   logic        s_err_q, n_err_q;
   logic [31:0] s_rd_q, n_rd_q;
   logic [31:0] s_word, n_word, s_lane, n_lane;

   always_comb begin
      s_word = '0;
      case (sdec.kind)
         F_RESP:  s_word = {31'h0, resp_q};
         F_CALL:  s_word = {30'h0, call_q};
         F_MPCST: s_word = mpc_stat_i;
         F_PPCST: s_word = ppc_stat_i;
         F_PPCEN: s_word = ppc_en_q;
         F_BRGEN: s_word = brg_en_q;
         F_NSM:   s_word[PORTS-1:0] = slice_ns_o[sdec.idx*PORTS +: PORTS];
         F_SPM:   s_word[PORTS-1:0] = slice_sp_o[sdec.idx*PORTS +: PORTS];
         F_ID:    s_word = {24'h0, id_byte(sdec.idx, 1'b1, ID_REV)};
         default: s_word = '0;
      endcase
   end

   always_comb begin
      n_word = '0;
      case (ndec.kind)
         F_NSPM:  n_word[PORTS-1:0] = slice_nsp_o[ndec.idx*PORTS +: PORTS];
         F_ID:    n_word = {24'h0, id_byte(ndec.idx, 1'b0, ID_REV)};
         default: n_word = '0;
      endcase
   end

   sec_cfg_lane u_slane (.word(s_word), .lo(sec_addr[1:0]), .size(sec_size), .lane(s_lane));
   sec_cfg_lane u_nlane (.word(n_word), .lo(nsw_addr[1:0]), .size(nsw_size), .lane(n_lane));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_q   <= 1'b0;
         call_q   <= 2'b00;
         ppc_en_q <= '0;
         brg_en_q <= '0;
         clr_q    <= '0;
         s_err_q  <= 1'b0;
         n_err_q  <= 1'b0;
         s_rd_q   <= '0;
         n_rd_q   <= '0;
      end else begin
         s_err_q <= s_wbad;
         n_err_q <= n_wbad;
         clr_q   <= '0;
         if (s_wok) begin
            case (sdec.kind)
               F_RESP:   resp_q   <= sec_wdata[0];
               F_CALL:   call_q   <= sec_wdata[1:0];
               F_PPCEN:  ppc_en_q <= sec_wdata & PPC_EN_MASK;
               F_BRGEN:  brg_en_q <= sec_wdata & BRG_EN_MASK;
               F_PPCCLR: clr_q    <= sec_wdata & PPC_EN_MASK;
               default:  ;
            endcase
         end
         if (sec_req && !sec_wr) s_rd_q <= s_lane;
         if (nsw_req && !nsw_wr) n_rd_q <= n_lane;
      end
   end

   assign resp_cfg_o    = resp_q;
   assign call_cfg_o    = call_q;
   assign ppc_irq_en_o  = ppc_en_q;
   assign ppc_irq_clr_o = clr_q;
   assign sec_err       = s_err_q;
   assign nsw_err       = n_err_q;
   assign sec_rdata     = s_rd_q;
   assign nsw_rdata     = n_rd_q;

   AST_CALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(sec_req && sec_wr) |=> $stable(call_cfg_o) && $stable(resp_cfg_o)); // R2
   AST_SUBWORD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_req && sec_wr && sec_size != SZ_WORD)
         |=> $stable(ppc_irq_en_o) && $stable(call_cfg_o) && !sec_err); // R5
   AST_BYTE_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_req && !sec_wr && sec_size == SZ_BYTE) |=> sec_rdata[31:8] == 24'h0); // R6
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (nsw_err || sec_err) |-> $past(sec_req || nsw_req)); // R11
   AST_CLR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      !(sec_req && sec_wr) |=> ppc_irq_clr_o == 32'h0); // R12
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(nsw_req && !nsw_wr) |=> $stable(nsw_rdata)); // R13

endmodule

// File: tb/sec_cfg_banks_bench.sv
`timescale 1ns/1ps
module sec_cfg_banks_bench;
   localparam int PORTS = 16;
   localparam int NSLICE = 10;
   localparam logic [1:0] B = 2'b00, H = 2'b01, W = 2'b10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sec_req = 0, sec_wr = 0, nsw_req = 0, nsw_wr = 0;
   logic [11:0] sec_addr = '0, nsw_addr = '0;
   logic [1:0]  sec_size = W, nsw_size = W;
   logic [31:0] sec_wdata = '0, nsw_wdata = '0, mpc_stat_i = '0, ppc_stat_i = '0;
   logic [31:0] sec_rdata, nsw_rdata, ppc_irq_en_o, ppc_irq_clr_o;
   logic        sec_err, nsw_err, resp_cfg_o;
   logic [1:0]  call_cfg_o;
   logic [NSLICE*PORTS-1:0] slice_ns_o, slice_sp_o, slice_nsp_o;

   int checks = 0, errors = 0;
   logic [31:0] q;

   always #2.5 clk = ~clk;

   sec_cfg_banks u_sec_cfg_banks (.*);

   typedef struct packed {
      logic        win;
      logic [11:0] addr;
      logic [31:0] wdata;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VEC [16] = '{
      '{1'b1, 12'h010, 32'hFFFF_FFFF, 32'h0000_0001, 4'd2},
      '{1'b1, 12'h014, 32'hFFFF_FFFF, 32'h0000_0003, 4'd2},
      '{1'b1, 12'h028, 32'hFFFF_FFFF, 32'h00F0_00F3, 4'd8},
      '{1'b1, 12'h048, 32'hFFFF_FFFF, 32'hFFFF_0000, 4'd8},
      '{1'b1, 12'h060, 32'hA5A5_1234, 32'h0000_1234, 4'd3},
      '{1'b1, 12'h074, 32'hFFFF_0001, 32'h0000_0001, 4'd3},
      '{1'b1, 12'h08C, 32'h0000_BEEF, 32'h0000_BEEF, 4'd3},
      '{1'b1, 12'h0A4, 32'h1111_5678, 32'h0000_5678, 4'd3},
      '{1'b1, 12'h0B0, 32'h0000_0F0F, 32'h0000_0F0F, 4'd3},
      '{1'b1, 12'h0C8, 32'h0000_00AA, 32'h0000_00AA, 4'd3},
      '{1'b0, 12'h0A0, 32'h0000_CAFE, 32'h0000_CAFE, 4'd4},
      '{1'b0, 12'h0B4, 32'h0000_0003, 32'h0000_0003, 4'd4},
      '{1'b0, 12'h0CC, 32'h0000_7777, 32'h0000_7777, 4'd4},
      '{1'b1, 12'h050, 32'hFFFF_FFFF, 32'h0000_0000, 4'd9},
      '{1'b1, 12'h040, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8},
      '{1'b1, 12'h024, 32'hFFFF_FFFF, 32'h0000_0000, 4'd7}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input logic win, input logic wr, input logic [11:0] a,
                         input logic [31:0] d, input logic [1:0] sz);
      @(negedge clk);
      if (win) begin
         sec_req = 1; sec_wr = wr; sec_addr = a; sec_wdata = d; sec_size = sz;
      end else begin
         nsw_req = 1; nsw_wr = wr; nsw_addr = a; nsw_wdata = d; nsw_size = sz;
      end
      @(negedge clk);
      sec_req = 0; sec_wr = 0; nsw_req = 0; nsw_wr = 0;
      q = win ? sec_rdata : nsw_rdata;
   endtask

   function automatic logic [31:0] sl(input logic [NSLICE*PORTS-1:0] bus, input int i);
      return {16'h0, bus[i*PORTS +: PORTS]};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 resp", {31'h0, resp_cfg_o}, 0);
      chk("R1 call", {30'h0, call_cfg_o}, 0);
      chk("R1 en", ppc_irq_en_o, 0);
      chk("R1 clr", ppc_irq_clr_o, 0);
      chk("R1 ns", {31'h0, |slice_ns_o}, 0);
      chk("R1 sp", {31'h0, |slice_sp_o}, 0);
      chk("R1 nsp", {31'h0, |slice_nsp_o}, 0);
      chk("R1 err", {30'h0, sec_err, nsw_err}, 0);
      access(1, 0, 12'h048, 0, W);
      chk("R1 brg en", q, 0);

      for (int i = 0; i < 16; i++) begin
         access(VEC[i].win, 1, VEC[i].addr, VEC[i].wdata, W);
         access(VEC[i].win, 0, VEC[i].addr, 0, W);
         chk($sformatf("R%0d table %0d", VEC[i].req, i), q, VEC[i].exp);
      end

      // R2 outputs follow stored values
      chk("R2 resp pin", {31'h0, resp_cfg_o}, 1);
      chk("R2 call pin", {30'h0, call_cfg_o}, 3);
      chk("R8 en pin", ppc_irq_en_o, 32'h00F0_00F3);
      // R3 secure slice buses
      chk("R3 ns6", sl(slice_ns_o, 6), 32'h1234);
      chk("R3 ns1", sl(slice_ns_o, 1), 32'h0001);
      chk("R3 ns5", sl(slice_ns_o, 5), 32'hBEEF);
      chk("R3 sp7", sl(slice_sp_o, 7), 32'h5678);
      chk("R3 sp0", sl(slice_sp_o, 0), 32'h0F0F);
      chk("R3 sp4", sl(slice_sp_o, 4), 32'h00AA);
      // R4 non-secure slice buses, separate from secure ones
      chk("R4 nsp6", sl(slice_nsp_o, 6), 32'hCAFE);
      chk("R4 nsp1", sl(slice_nsp_o, 1), 32'h0003);
      chk("R4 nsp5", sl(slice_nsp_o, 5), 32'h7777);
      access(1, 0, 12'h0A0, 0, W);
      chk("R4 secure 0xA0 is sp6", q, 0);

      // R6 lane extraction
      access(1, 0, 12'h04A, 0, B); chk("R6 byte2", q, 32'hFF);
      access(1, 0, 12'h049, 0, B); chk("R6 byte1", q, 32'h00);
      access(1, 0, 12'h04A, 0, H); chk("R6 half hi", q, 32'hFFFF);
      access(1, 0, 12'h02A, 0, H); chk("R6 half en", q, 32'h00F0);
      access(1, 0, 12'h028, 0, B); chk("R6 byte0", q, 32'hF3);
      // R13 hold
      @(negedge clk); chk("R13 hold", sec_rdata, 32'hF3);

      // R5 sub-word writes
      access(1, 1, 12'h010, 0, B);
      chk("R5 err", {31'h0, sec_err}, 0);
      chk("R5 resp", {31'h0, resp_cfg_o}, 1);
      access(1, 1, 12'h060, 0, H);
      chk("R5 ns6", sl(slice_ns_o, 6), 32'h1234);

      // R11 read-only write
      access(1, 1, 12'h020, 32'hFFFF_FFFF, W);
      chk("R11 err pulse", {31'h0, sec_err}, 1);
      @(negedge clk); chk("R11 err drop", {31'h0, sec_err}, 0);
      access(1, 1, 12'h200, 32'h1, W);
      chk("R11 undecoded err", {31'h0, sec_err}, 1);
      access(1, 0, 12'h200, 0, W); chk("R7 undecoded", q, 0);
      access(1, 0, 12'h044, 0, W); chk("R7 brg clr", q, 0);
      access(1, 1, 12'hFE0, 32'h0, W);
      chk("R11 id write err", {31'h0, sec_err}, 1);

      // R12 status inputs and clear pulse
      ppc_stat_i = 32'h0012_0041; mpc_stat_i = 32'h0003_0005;
      access(1, 0, 12'h020, 0, W); chk("R12 ppc stat", q, 32'h0012_0041);
      access(1, 0, 12'h01C, 0, W); chk("R12 mpc stat", q, 32'h0003_0005);
      access(1, 1, 12'h024, 32'hFFFF_FFFF, W);
      chk("R12 clr pulse", ppc_irq_clr_o, 32'h00F0_00F3);
      @(negedge clk); chk("R12 clr drop", ppc_irq_clr_o, 0);

      // R9 read-as-zero offsets
      access(0, 1, 12'h090, 32'hFFFF_FFFF, W);
      chk("R9 ns 0x90 err", {31'h0, nsw_err}, 1);
      access(0, 0, 12'h090, 0, W); chk("R9 ns 0x90", q, 0);
      access(1, 0, 12'h090, 0, W); chk("R9 s 0x90", q, 0);
      access(0, 1, 12'h060, 32'h0, W);
      chk("R11 ns bad err", {31'h0, nsw_err}, 1);
      chk("R11 ns6 kept", sl(slice_ns_o, 6), 32'h1234);

      // R10 identification bytes
      access(1, 0, 12'hFE0, 0, W); chk("R10 s part", q, 32'h52);
      access(0, 0, 12'hFE0, 0, W); chk("R10 ns part", q, 32'h53);
      access(1, 0, 12'hFE8, 0, W); chk("R10 rev", q, 32'h0B);
      access(0, 0, 12'hFFC, 0, W); chk("R10 last", q, 32'hB1);
      access(1, 0, 12'hFD0, 0, W); chk("R10 first", q, 32'h04);
      access(0, 0, 12'hFF4, 0, B); chk("R10 cid1", q, 32'hF0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule